// File: doc/BRIEF.md
# NAND ECC Read Status Sequencer

This block sits on the controller side of an asynchronous NAND flash bus. Once a page read has been started, a request on `start_i` makes it wait for the device's ready/busy line to report ready. It then writes the status command, reads one status byte back, and writes the command that returns the device to read mode. Bit 0 of the captured byte says whether the on-die ECC found more errors in a sector than it could correct. That bit is reported on `ecc_fail_o`, the whole byte is held on `status_o`, and `done_o` pulses once when the sequence ends.

A request on `reset_req_i` writes the reset command instead. The block then waits out the minimum time before the busy line is valid and waits for ready. The first reset after the block leaves reset may keep the device busy far longer than any later one, so each case has its own busy limit. Every bus delay is given as a parameter in nanoseconds and turned into clock cycles with rounding up. A busy line held low past its limit ends the sequence early with `timeout_o`.

Top module: `nand_ecc_status_seq`

## Requirements
- R1: A status request accepted in idle waits until the synchronised ready/busy line is high, then writes command 70h: CLE high, CE# low, the byte driven on the bus, and WE# low for at least T_WP_NS before its rising edge.
- R2: RE# falls no earlier than T_WHR_NS (60 ns) after the rising WE# edge of the 70h command.
- R3: RE# stays low for at least the larger of T_REA_NS + T_IN_SETUP_NS and T_RC_NS. The byte on the bus at the edge where RE# rises is held on `status_o`, and `ecc_fail_o` equals its bit 0 (1 = uncorrectable).
- R4: After the status byte, command 00h is written with CLE high. Its WE# falling edge comes at least T_RHW_NS (100 ns) after RE# rises. The status flow writes exactly the two commands 70h and 00h, in that order.
- R5: `busy_o` is high from the cycle after a request is accepted through the cycle of `done_o`. `done_o` is high for exactly one cycle per sequence.
- R6: A reset request writes command FFh only. The block then waits at least T_WB_NS (100 ns) after the WE# rise before it samples ready/busy, and it ends only once the device reports ready.
- R7: The first reset sequence after block reset uses the T_RST_FIRST_NS busy limit (default 1 ms). Every later reset uses T_RST_LATER_NS (default 5 µs). If ready/busy stays low past the active limit, `timeout_o` is 1 at done.
- R8: If ready/busy stays low for longer than T_RD_BUSY_NS while the block waits before a status read, the sequence ends with `timeout_o`=1 and `ecc_fail_o`=0, and no command is written.
- R9: `start_i` and `reset_req_i` are ignored while a sequence runs. If both are high in the same idle cycle, the reset is performed.
- R10: While in reset and in idle, CE#, WE# and RE# are high, CLE is low, the bus is not driven, and `done_o` and `busy_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a status check after a read |
| reset_req_i | input | 1 | Request a device reset |
| rb_n_i | input | 1 | Device ready/busy, low = busy (asynchronous) |
| io_in_i | input | 8 | Data bus from the device |
| cle_o | output | 1 | Command latch enable |
| ce_n_o | output | 1 | Chip enable, active low |
| we_n_o | output | 1 | Write strobe, active low |
| re_n_o | output | 1 | Read strobe, active low |
| io_out_o | output | 8 | Data bus toward the device |
| io_oe_o | output | 1 | Drive enable for io_out_o |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| ecc_fail_o | output | 1 | Uncorrectable on-die ECC error reported |
| timeout_o | output | 1 | Busy limit exceeded in the last sequence |
| status_o | output | 8 | Last captured status byte |

## Verification
The hardest case to reach is the difference between the first-reset and later-reset busy limits, together with the timeouts. At the default limits this would take hundreds of thousands of cycles, and only the block's private reset history decides which limit applies. The bench therefore builds the block with scaled-down nanosecond limits and runs two reset sequences in a row against a device model that holds ready/busy low for a span lying between the two limits. The first reset must then finish cleanly and the second must time out. A status request issued while the line is already held low past the read limit checks the early-exit path, in which no command is written.

// File: rtl/nand_stat_pkg.sv
`timescale 1ns/1ps
package nand_stat_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RDY_WAIT,
        S_CMD_LO,
        S_CMD_HI,
        S_WHR,
        S_RE_LO,
        S_RHW,
        S_WB,
        S_RST_WAIT,
        S_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        LIM_READ      = 2'd0,
        LIM_RST_FIRST = 2'd1,
        LIM_RST_LATER = 2'd2
    } busy_lim_e;

    localparam logic [7:0] OP_STATUS    = 8'h70;
    localparam logic [7:0] OP_READ_MODE = 8'h00;
    localparam logic [7:0] OP_RESET     = 8'hFF;

    typedef struct packed {
        seq_state_e  state;
        logic [7:0]  cmd;
        logic [7:0]  status;
        logic        ecc_fail;
        logic        timeout;
        logic        first_rst;
        logic        cle;
        logic        ce_n;
        logic        we_n;
        logic        re_n;
        logic [7:0]  io_out;
        logic        io_oe;
    } seq_regs_t;

    // nanoseconds to whole clock cycles, rounded up, never below one
    function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                                 input int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        if (c == 0) c = 1;
        return c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/nst_rb_sync.sv
`timescale 1ns/1ps
module nst_rb_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    chain_q[g] <= 1'b1;
                end else begin
                    if (g == 0) chain_q[g] <= d_i;
                    else        chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/nst_phase_timer.sv
`timescale 1ns/1ps
module nst_phase_timer #(
    parameter int unsigned W = 5
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)             cnt_d = val_i;
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    p_timer_counts_down_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/nst_busy_guard.sv
`timescale 1ns/1ps
module nst_busy_guard
    import nand_stat_pkg::*;
#(
    parameter int unsigned LIM_RD    = 14000,
    parameter int unsigned LIM_FIRST = 200000,
    parameter int unsigned LIM_LATER = 1000
) (
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      arm_i,
    input  logic      rb_ready_i,
    input  busy_lim_e sel_i,
    output logic      over_o
);
    localparam int unsigned LIM_MAX = max2(max2(LIM_RD, LIM_FIRST), LIM_LATER);
    localparam int unsigned CW      = $clog2(LIM_MAX + 1);

    logic [CW-1:0] cnt_d, cnt_q, lim;

    always_comb begin
        unique case (sel_i)
            LIM_RST_FIRST: lim = CW'(LIM_FIRST);
            LIM_RST_LATER: lim = CW'(LIM_LATER);
            default:       lim = CW'(LIM_RD);
        endcase
    end

    always_comb begin
        cnt_d = cnt_q;
        if (!arm_i)                          cnt_d = '0;
        else if (!rb_ready_i && cnt_q < lim) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign over_o = arm_i && (cnt_q >= lim);

    p_guard_idle_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !arm_i |=> (cnt_q == '0));
endmodule

// File: rtl/nand_ecc_status_seq.sv
`timescale 1ns/1ps
module nand_ecc_status_seq
    import nand_stat_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS  = 5,
    parameter int unsigned T_WP_NS        = 10,
    parameter int unsigned T_WH_NS        = 10,
    parameter int unsigned T_WHR_NS       = 60,
    parameter int unsigned T_REA_NS       = 16,
    parameter int unsigned T_IN_SETUP_NS  = 4,
    parameter int unsigned T_RC_NS        = 20,
    parameter int unsigned T_RHW_NS       = 100,
    parameter int unsigned T_WB_NS        = 100,
    parameter int unsigned T_RD_BUSY_NS   = 70000,
    parameter int unsigned T_RST_FIRST_NS = 1000000,
    parameter int unsigned T_RST_LATER_NS = 5000,
    parameter int unsigned SYNC_STAGES    = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       start_i,
    input  logic       reset_req_i,
    input  logic       rb_n_i,
    input  logic [7:0] io_in_i,
    output logic       cle_o,
    output logic       ce_n_o,
    output logic       we_n_o,
    output logic       re_n_o,
    output logic [7:0] io_out_o,
    output logic       io_oe_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       ecc_fail_o,
    output logic       timeout_o,
    output logic [7:0] status_o
);
    localparam int unsigned N_WP   = ns_to_cycles(T_WP_NS, CLK_PERIOD_NS);
    localparam int unsigned N_WH   = ns_to_cycles(T_WH_NS, CLK_PERIOD_NS);
    localparam int unsigned N_WHR  = ns_to_cycles(T_WHR_NS, CLK_PERIOD_NS);
    localparam int unsigned N_RE   = max2(ns_to_cycles(T_REA_NS + T_IN_SETUP_NS, CLK_PERIOD_NS),
                                          ns_to_cycles(T_RC_NS, CLK_PERIOD_NS));
    localparam int unsigned N_RHW  = ns_to_cycles(T_RHW_NS, CLK_PERIOD_NS);
    localparam int unsigned N_WB   = ns_to_cycles(T_WB_NS, CLK_PERIOD_NS);
    localparam int unsigned N_RDB  = ns_to_cycles(T_RD_BUSY_NS, CLK_PERIOD_NS);
    localparam int unsigned N_RSTF = ns_to_cycles(T_RST_FIRST_NS, CLK_PERIOD_NS);
    localparam int unsigned N_RSTL = ns_to_cycles(T_RST_LATER_NS, CLK_PERIOD_NS);
    localparam int unsigned N_DMAX = max2(max2(max2(N_WP, N_WH), max2(N_WHR, N_RE)),
                                          max2(N_RHW, N_WB));
    localparam int unsigned TW     = $clog2(N_DMAX + 1);
    localparam int unsigned ACW    = $clog2(N_DMAX + 2);

    seq_regs_t  d, q;
    logic       rb_ready;
    logic       guard_arm, guard_over;
    busy_lim_e  guard_sel;
    logic       tmr_load, tmr_zero;
    logic [TW-1:0] tmr_val;

    nst_rb_sync #(.STAGES(SYNC_STAGES)) u_rb_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (rb_n_i),
        .q_o    (rb_ready)
    );

    nst_phase_timer #(.W(TW)) u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );

    assign guard_arm = (q.state == S_RDY_WAIT) || (q.state == S_RST_WAIT);
    assign guard_sel = (q.state == S_RST_WAIT) ? (q.first_rst ? LIM_RST_FIRST : LIM_RST_LATER)
                                               : LIM_READ;

    nst_busy_guard #(
        .LIM_RD    (N_RDB),
        .LIM_FIRST (N_RSTF),
        .LIM_LATER (N_RSTL)
    ) u_guard (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .arm_i      (guard_arm),
        .rb_ready_i (rb_ready),
        .sel_i      (guard_sel),
        .over_o     (guard_over)
    );

    always_comb begin
        d        = q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (q.state)
            S_IDLE: begin
                if (reset_req_i) begin
                    d.state    = S_CMD_LO;
                    d.cmd      = OP_RESET;
                    d.timeout  = 1'b0;
                    d.ecc_fail = 1'b0;
                    tmr_load   = 1'b1;
                    tmr_val    = TW'(N_WP - 1);
                end else if (start_i) begin
                    d.state    = S_RDY_WAIT;
                    d.timeout  = 1'b0;
                    d.ecc_fail = 1'b0;
                end
            end
            S_RDY_WAIT: begin
                if (guard_over) begin
                    d.state   = S_DONE;
                    d.timeout = 1'b1;
                end else if (rb_ready) begin
                    d.state  = S_CMD_LO;
                    d.cmd    = OP_STATUS;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(N_WP - 1);
                end
            end
            S_CMD_LO: begin
                if (tmr_zero) begin
                    d.state  = S_CMD_HI;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(N_WH - 1);
                end
            end
            S_CMD_HI: begin
                if (tmr_zero) begin
                    if (q.cmd == OP_STATUS) begin
                        d.state  = S_WHR;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(N_WHR - 1);
                    end else if (q.cmd == OP_RESET) begin
                        d.state  = S_WB;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(N_WB - 1);
                    end else begin
                        d.state = S_DONE;
                    end
                end
            end
            S_WHR: begin
                if (tmr_zero) begin
                    d.state  = S_RE_LO;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(N_RE - 1);
                end
            end
            S_RE_LO: begin
                if (tmr_zero) begin
                    d.state    = S_RHW;
                    d.status   = io_in_i;
                    d.ecc_fail = io_in_i[0];
                    tmr_load   = 1'b1;
                    tmr_val    = TW'(N_RHW - 1);
                end
            end
            S_RHW: begin
                if (tmr_zero) begin
                    d.state  = S_CMD_LO;
                    d.cmd    = OP_READ_MODE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(N_WP - 1);
                end
            end
            S_WB: begin
                if (tmr_zero) d.state = S_RST_WAIT;
            end
            S_RST_WAIT: begin
                if (guard_over) begin
                    d.state     = S_DONE;
                    d.timeout   = 1'b1;
                    d.first_rst = 1'b0;
                end else if (rb_ready) begin
                    d.state     = S_DONE;
                    d.first_rst = 1'b0;
                end
            end
            S_DONE: begin
                d.state = S_IDLE;
            end
            default: begin
                d.state = S_IDLE;
            end
        endcase

        // bus pins follow the next state so they leave the flops glitch-free
        d.ce_n   = (d.state == S_IDLE) || (d.state == S_DONE);
        d.cle    = (d.state == S_CMD_LO) || (d.state == S_CMD_HI);
        d.we_n   = (d.state != S_CMD_LO);
        d.re_n   = (d.state != S_RE_LO);
        d.io_oe  = d.cle;
        d.io_out = d.cle ? d.cmd : 8'h00;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q           <= '0;
            q.state     <= S_IDLE;
            q.first_rst <= 1'b1;
            q.ce_n      <= 1'b1;
            q.we_n      <= 1'b1;
            q.re_n      <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign cle_o      = q.cle;
    assign ce_n_o     = q.ce_n;
    assign we_n_o     = q.we_n;
    assign re_n_o     = q.re_n;
    assign io_out_o   = q.io_out;
    assign io_oe_o    = q.io_oe;
    assign busy_o     = (q.state != S_IDLE);
    assign done_o     = (q.state == S_DONE);
    assign ecc_fail_o = q.ecc_fail;
    assign timeout_o  = q.timeout;
    assign status_o   = q.status;

    // interval counters kept for the timing properties below
    logic [ACW-1:0] we_hi_cnt_q, re_hi_cnt_q, re_lo_cnt_q;
    localparam logic [ACW-1:0] ACNT_MAX = '1;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            we_hi_cnt_q <= ACNT_MAX;
            re_hi_cnt_q <= ACNT_MAX;
            re_lo_cnt_q <= '0;
        end else begin
            if (!we_n_o)                      we_hi_cnt_q <= '0;
            else if (we_hi_cnt_q != ACNT_MAX) we_hi_cnt_q <= we_hi_cnt_q + 1'b1;
            if (!re_n_o)                      re_hi_cnt_q <= '0;
            else if (re_hi_cnt_q != ACNT_MAX) re_hi_cnt_q <= re_hi_cnt_q + 1'b1;
            if (re_n_o)                       re_lo_cnt_q <= '0;
            else if (re_lo_cnt_q != ACNT_MAX) re_lo_cnt_q <= re_lo_cnt_q + 1'b1;
        end
    end

    p_strobe_in_cmd_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !we_n_o |-> (cle_o && io_oe_o && !ce_n_o));
    p_whr_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(re_n_o) |-> (we_hi_cnt_q >= ACW'(N_WHR)));
    p_re_width_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(re_n_o) |-> (re_lo_cnt_q >= ACW'(N_RE)));
    p_rhw_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(we_n_o) |-> (re_hi_cnt_q >= ACW'(N_RHW)));
    p_done_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);
    p_timeout_clean_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && timeout_o && q.cmd != OP_RESET) |-> !ecc_fail_o);
    p_hold_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !done_o) |=> busy_o);
    p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> (ce_n_o && we_n_o && re_n_o && !cle_o && !io_oe_o));
endmodule

// File: tb/nand_ecc_status_seq_bench.sv
`timescale 1ns/1ps
module nand_ecc_status_seq_bench;
    // scaled-down busy limits: read 400, first reset 800, later reset 200 cycles
    localparam int unsigned RD_LIM_NS  = 2000;
    localparam int unsigned RF_LIM_NS  = 4000;
    localparam int unsigned RL_LIM_NS  = 1000;
    localparam int unsigned NVEC       = 6;
    // {status byte, busy cycles before ready}
    localparam logic [15:0] VEC [0:NVEC-1] = '{
        {8'hE0, 8'd0}, {8'hC1, 8'd12}, {8'h00, 8'd50},
        {8'h81, 8'd3}, {8'hFE, 8'd100}, {8'h41, 8'd25}
    };

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, rst_req = 1'b0, rb_n = 1'b1;
    logic [7:0] dev_status = 8'h00;
    logic [7:0] io_in, io_out, status;
    logic cle, ce_n, we_n, re_n, io_oe, busy, done, ecc_fail, timeout;

    always #2.5 clk = ~clk;
    assign io_in = (!re_n) ? dev_status : 8'h00;

    nand_ecc_status_seq #(
        .T_RD_BUSY_NS   (RD_LIM_NS),
        .T_RST_FIRST_NS (RF_LIM_NS),
        .T_RST_LATER_NS (RL_LIM_NS)
    ) u_nand_ecc_status_seq (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .reset_req_i(rst_req),
        .rb_n_i(rb_n), .io_in_i(io_in), .cle_o(cle), .ce_n_o(ce_n), .we_n_o(we_n),
        .re_n_o(re_n), .io_out_o(io_out), .io_oe_o(io_oe), .busy_o(busy),
        .done_o(done), .ecc_fail_o(ecc_fail), .timeout_o(timeout), .status_o(status)
    );

    int n_chk = 0, n_bad = 0;
    logic [7:0] cmd_log [0:7];
    int cmd_cnt = 0;
    int dev_busy_ns = 0;
    realtime t_we_rise = 0, t_we_fall = 0, t_re_fall = 0, t_re_rise = 0, t_done = 0;
    realtime min_whr, min_rhw, min_re_low, min_we_low;
    bit re_fell_seen = 0, re_pending = 0, we_fell_seen = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // device model: command latch and reset busy
    always @(posedge we_n) begin
        if (ce_n === 1'b0 && cle === 1'b1 && io_oe === 1'b1) begin
            if (cmd_cnt < 8) cmd_log[cmd_cnt] = io_out;
            cmd_cnt++;
            t_we_rise = $realtime;
            if (we_fell_seen && ($realtime - t_we_fall) < min_we_low)
                min_we_low = $realtime - t_we_fall;
            if (io_out == 8'hFF && dev_busy_ns > 0) begin
                fork
                    begin
                        #50;
                        rb_n = 1'b0;
                        #(dev_busy_ns);
                        rb_n = 1'b1;
                    end
                join_none
            end
        end
    end

    always @(negedge we_n) begin
        t_we_fall = $realtime;
        we_fell_seen = 1;
        if (re_pending) begin
            if ((t_we_fall - t_re_rise) < min_rhw) min_rhw = t_we_fall - t_re_rise;
            re_pending = 0;
        end
    end

    always @(negedge re_n) begin
        t_re_fall = $realtime;
        re_fell_seen = 1;
        if ((t_re_fall - t_we_rise) < min_whr) min_whr = t_re_fall - t_we_rise;
    end

    always @(posedge re_n) begin
        if (re_fell_seen) begin
            t_re_rise = $realtime;
            if ((t_re_rise - t_re_fall) < min_re_low) min_re_low = t_re_rise - t_re_fall;
            re_pending = 1;
        end
    end

    task automatic clear_log();
        cmd_cnt    = 0;
        min_whr    = 1.0e9;
        min_rhw    = 1.0e9;
        min_re_low = 1.0e9;
        min_we_low = 1.0e9;
        re_pending = 0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 0;
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            if (done) begin
                seen   = 1;
                t_done = $realtime;
                break;
            end
        end
        if (!seen) chk("R5 done watchdog", 32'd0, 32'd1);
    endtask

    task automatic run_status(input logic [7:0] sb, input int busy_cyc);
        bit seen;
        clear_log();
        dev_status = sb;
        if (busy_cyc > 0) begin
            @(negedge clk) rb_n = 1'b0;
            repeat (3) @(negedge clk);
        end
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk("R5 busy after accept", {31'd0, busy}, 32'd1);
        repeat (busy_cyc) @(negedge clk);
        rb_n = 1'b1;
        wait_done(seen);
        chk("R3 status byte", {24'd0, status}, {24'd0, sb});
        chk("R3 ecc_fail is bit0", {31'd0, ecc_fail}, {31'd0, sb[0]});
        chk("R8 no timeout", {31'd0, timeout}, 32'd0);
        chk("R4 two commands", cmd_cnt, 32'd2);
        chk("R1 first command 70h", {24'd0, cmd_log[0]}, 32'h70);
        chk("R4 second command 00h", {24'd0, cmd_log[1]}, 32'h00);
        chk("R1 WE low width", {31'd0, min_we_low >= 10.0}, 32'd1);
        chk("R2 WE rise to RE fall", {31'd0, min_whr >= 60.0}, 32'd1);
        chk("R3 RE low width", {31'd0, min_re_low >= 20.0}, 32'd1);
        chk("R4 RE rise to WE fall", {31'd0, min_rhw >= 100.0}, 32'd1);
        @(negedge clk);
        chk("R5 done one cycle", {31'd0, done}, 32'd0);
        chk("R5 idle after done", {31'd0, busy}, 32'd0);
    endtask

    task automatic run_reset(input int busy_ns, input bit exp_to, input string tag);
        bit seen;
        clear_log();
        dev_busy_ns = busy_ns;
        @(negedge clk) rst_req = 1'b1;
        @(negedge clk) rst_req = 1'b0;
        wait_done(seen);
        chk({tag, " timeout flag"}, {31'd0, timeout}, {31'd0, exp_to});
        chk("R6 only FFh written", cmd_cnt, 32'd1);
        chk("R6 command FFh", {24'd0, cmd_log[0]}, 32'hFF);
        chk("R6 tWB wait", {31'd0, (t_done - t_we_rise) >= 100.0}, 32'd1);
        if (busy_ns > 0 && !exp_to)
            chk("R6 waits for ready", {31'd0, (t_done - t_we_rise) >= (50.0 + busy_ns)}, 32'd1);
        wait (rb_n === 1'b1);
        dev_busy_ns = 0;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (2000 * 75) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        bit seen;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 CE# high in reset", {31'd0, ce_n}, 32'd1);
        chk("R10 WE# high in reset", {31'd0, we_n}, 32'd1);
        chk("R10 RE# high in reset", {31'd0, re_n}, 32'd1);
        chk("R10 bus idle in reset", {30'd0, cle, io_oe}, 32'd0);
        chk("R10 done/busy low", {30'd0, done, busy}, 32'd0);
        @(negedge clk) rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 idle pins after reset", {28'd0, ce_n, we_n, re_n, cle}, 32'hE);

        // table of status bytes and busy lengths
        for (int k = 0; k < NVEC; k++) begin
            run_status(VEC[k][15:8], int'(VEC[k][7:0]));
        end

        // R8: busy past the read limit; last table entry left ecc_fail at 1
        clear_log();
        @(negedge clk) rb_n = 1'b0;
        repeat (3) @(negedge clk);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        wait_done(seen);
        chk("R8 timeout flagged", {31'd0, timeout}, 32'd1);
        chk("R8 no command written", cmd_cnt, 32'd0);
        chk("R8 ecc_fail cleared", {31'd0, ecc_fail}, 32'd0);
        rb_n = 1'b1;
        repeat (5) @(negedge clk);

        // R7: same busy span, first reset within long limit, second past short one
        run_reset(2000, 1'b0, "R7 first reset");
        run_reset(2000, 1'b1, "R7 later reset");
        run_reset(0, 1'b0, "R6 no busy reset");

        // R9: requests during a running sequence are ignored
        clear_log();
        dev_status = 8'h10;
        @(negedge clk) rb_n = 1'b0;
        repeat (3) @(negedge clk);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (5) @(negedge clk);
        rst_req = 1'b1;
        start   = 1'b1;
        @(negedge clk);
        rst_req = 1'b0;
        start   = 1'b0;
        repeat (10) @(negedge clk);
        rb_n = 1'b1;
        wait_done(seen);
        chk("R9 ignored requests: count", cmd_cnt, 32'd2);
        chk("R9 ignored requests: 70h", {24'd0, cmd_log[0]}, 32'h70);
        @(negedge clk);
        chk("R9 idle after sequence", {31'd0, busy}, 32'd0);

        // R9: both requests in the same idle cycle, reset wins
        clear_log();
        @(negedge clk) begin rst_req = 1'b1; start = 1'b1; end
        @(negedge clk) begin rst_req = 1'b0; start = 1'b0; end
        wait_done(seen);
        chk("R9 reset priority count", cmd_cnt, 32'd1);
        chk("R9 reset priority FFh", {24'd0, cmd_log[0]}, 32'hFF);
        repeat (3) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule